// File: doc/BRIEF.md
# I2C Controller Master and Arbitration Status Register

This block holds the 8-bit status word of an I2C controller. It records whether the local node owns the bus as master and whether it has lost arbitration. It also keeps six flags for other bus events: extension code, address match, transfer direction, acknowledge, start seen and stop seen. Its inputs are one-cycle event pulses from the bus engine, plus a release request, the interface enable level, a wakeup-mode level, and a CPU read strobe with a single-bit qualifier. Its only output is the register value. The CPU samples that value during its read strobe.

The master flag has several clear sources, and each of them overrides a start generated in the same cycle. The arbitration-lost flag clears after a full read of the word. It also clears after a single-bit access aimed at any other bit. When the wakeup mode is switched off, the word is frozen until the next start or stop condition is detected.

Top module: `i2c_mstat_reg`

## Requirements
- R1: Reset makes `stat` 0x00. Bit positions: 7 master, 6 arbitration-lost, 5 extension code, 4 address match, 3 direction (1 = transmit), 2 acknowledge detected, 1 start detected, 0 stop detected.
- R2: A `start_gen` pulse sets the master flag at the next clock edge.
- R3: `stop_det`, `arb_lost` or `comm_rel` clears the master flag at the next edge. Any of them wins over a `start_gen` in the same cycle.
- R4: `arb_lost` sets the arbitration-lost flag and clears the master flag at the same edge.
- R5: A full read (`rd_stb`=1, `rd_bit`=0) clears the arbitration-lost flag at the edge ending the strobe. `stat` still shows the old value during the strobe. An `arb_lost` in the same cycle keeps the flag at 1.
- R6: A single-bit access (`rd_stb`=1, `rd_bit`=1) with `rd_sel` not equal to 6 clears the arbitration-lost flag. With `rd_sel`=6 the flag is left as it is.
- R7: While `if_en` is 0, `stat` becomes and stays 0x00 and every event is ignored. This includes the edge where `if_en` falls.
- R8: `start_det` sets bit 1 and clears bit 0. `stop_det` sets bit 0 and clears bit 1. If both arrive together, bit 0 ends at 1 and bit 1 at 0.
- R9: `ext_code` sets bit 5 and `addr_match` sets bit 4. Each of these bits clears on `start_det` or `stop_det`, unless its own set pulse arrives in the same cycle.
- R10: `dir_upd` loads `dir_tx` into bit 3, and `ack_upd` loads `ack_val` into bit 2. Both bits clear on `stop_det`, unless a load arrives in the same cycle.
- R11: Suppose `wkup_en` was 1 in one cycle and is 0 in the next, with `if_en` high. From the following cycle on, `stat` holds every bit and read clears are ignored. This lasts until a cycle with `start_det` or `stop_det`. That cycle is applied normally and ends the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable level |
| wkup_en | input | 1 | Address-match wakeup mode level |
| start_gen | input | 1 | Pulse: this node generated a start |
| stop_det | input | 1 | Pulse: stop condition detected |
| start_det | input | 1 | Pulse: start condition detected |
| arb_lost | input | 1 | Pulse: arbitration lost |
| comm_rel | input | 1 | Pulse: release from communication |
| ext_code | input | 1 | Pulse: extension code received |
| addr_match | input | 1 | Pulse: own address matched |
| dir_upd | input | 1 | Pulse: load direction flag |
| dir_tx | input | 1 | Direction value to load (1 = transmit) |
| ack_upd | input | 1 | Pulse: load acknowledge flag |
| ack_val | input | 1 | Acknowledge value to load |
| rd_stb | input | 1 | CPU access strobe |
| rd_bit | input | 1 | 1 = single-bit access, 0 = full read |
| rd_sel | input | 3 | Bit addressed by a single-bit access |
| stat | output | 8 | Status register value |

## Verification
The hardest state to reach is the wakeup hold. To enter it, `wkup_en` must go high and then low while `if_en` stays high. The hold must then survive events and reads until a start or stop detection releases it. The random stimulus toggles `wkup_en` rarely and keeps start and stop detections sparse, so the bench spends long stretches frozen with arbitration losses and reads arriving. A directed sequence also enters the hold, checks that an arbitration loss is not recorded, and then checks the stop that releases it. Collisions are driven directly: loss with start generation, loss with a full read, and start with stop.

// File: rtl/i2c_mstat_pkg.sv
package i2c_mstat_pkg;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned SEL_W  = $clog2(STAT_W);

  localparam int unsigned BIT_MST = 7;
  localparam int unsigned BIT_ALD = 6;
  localparam int unsigned BIT_EXC = 5;
  localparam int unsigned BIT_ADM = 4;
  localparam int unsigned BIT_DIR = 3;
  localparam int unsigned BIT_ACK = 2;
  localparam int unsigned BIT_STD = 1;
  localparam int unsigned BIT_SPD = 0;

  localparam int unsigned N_STICKY = 2;
  localparam int unsigned N_LOAD   = 2;

  typedef struct packed {
    logic start_gen;
    logic stop_det;
    logic start_det;
    logic arb_lost;
    logic comm_rel;
  } bus_ev_t;

  // Master ownership: any clear source overrides a start generation
  function automatic logic mst_next(input logic cur, input logic gen, input logic clr);
    if (clr)      return 1'b0;
    else if (gen) return 1'b1;
    else          return cur;
  endfunction

  // Arbitration-lost: a new loss beats a read-triggered clear
  function automatic logic ald_next(input logic cur, input logic lost, input logic rclr);
    if (lost)      return 1'b1;
    else if (rclr) return 1'b0;
    else           return cur;
  endfunction

  // CPU access that consumes the arbitration-lost flag
  function automatic logic rd_clears_ald(input logic stb, input logic bit_acc,
                                         input logic [SEL_W-1:0] sel);
    return stb && (!bit_acc || (sel != SEL_W'(BIT_ALD)));
  endfunction

endpackage

// File: rtl/i2c_mstat_wake.sv
module i2c_mstat_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic if_en,
  input  logic wkup_en,
  input  logic start_det,
  input  logic stop_det,
  output logic hold
);
  logic wkup_q;
  logic frz_q;
  logic wk_fall;
  logic bus_cond;

  assign wk_fall  = wkup_q && !wkup_en;
  assign bus_cond = start_det || stop_det;
  assign hold     = frz_q && !bus_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wkup_q <= 1'b0;
      frz_q  <= 1'b0;
    end else begin
      wkup_q <= if_en ? wkup_en : 1'b0;
      if (!if_en || bus_cond) frz_q <= 1'b0;
      else if (wk_fall)       frz_q <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_mstat_arb.sv
module i2c_mstat_arb
  import i2c_mstat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    if_en,
  input  logic    hold,
  input  bus_ev_t ev,
  input  logic    ald_rd_clr,
  output logic    mst,
  output logic    ald
);
  logic mst_clr;
  logic mst_d;
  logic ald_d;

  assign mst_clr = ev.stop_det || ev.arb_lost || ev.comm_rel;

  always_comb begin
    if (!if_en) begin
      mst_d = 1'b0;
      ald_d = 1'b0;
    end else if (hold) begin
      mst_d = mst;
      ald_d = ald;
    end else begin
      mst_d = mst_next(mst, ev.start_gen, mst_clr);
      ald_d = ald_next(ald, ev.arb_lost, ald_rd_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst <= 1'b0;
      ald <= 1'b0;
    end else begin
      mst <= mst_d;
      ald <= ald_d;
    end
  end
endmodule

// File: rtl/i2c_mstat_evflags.sv
module i2c_mstat_evflags
  import i2c_mstat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                if_en,
  input  logic                hold,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic [N_STICKY-1:0] sticky_set,
  input  logic [N_LOAD-1:0]   load_upd,
  input  logic [N_LOAD-1:0]   load_val,
  output logic [N_STICKY-1:0] sticky_q,
  output logic [N_LOAD-1:0]   load_q,
  output logic                std_q,
  output logic                spd_q
);
  logic any_cond;
  assign any_cond = start_det || stop_det;

  // Flags set by a pulse and cleared by either bus condition
  for (genvar k = 0; k < N_STICKY; k++) begin : g_sticky
    logic d;
    always_comb begin
      if (!if_en)              d = 1'b0;
      else if (hold)           d = sticky_q[k];
      else if (sticky_set[k])  d = 1'b1;
      else if (any_cond)       d = 1'b0;
      else                     d = sticky_q[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q[k] <= 1'b0;
      else        sticky_q[k] <= d;
    end
  end

  // Flags loaded from a value, cleared by a stop condition
  for (genvar k = 0; k < N_LOAD; k++) begin : g_load
    logic d;
    always_comb begin
      if (!if_en)           d = 1'b0;
      else if (hold)        d = load_q[k];
      else if (load_upd[k]) d = load_val[k];
      else if (stop_det)    d = 1'b0;
      else                  d = load_q[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q[k] <= 1'b0;
      else        load_q[k] <= d;
    end
  end

  // Start/stop seen: mutually exclusive, stop dominant
  logic std_d, spd_d;
  always_comb begin
    std_d = std_q;
    spd_d = spd_q;
    if (!if_en) begin
      std_d = 1'b0;
      spd_d = 1'b0;
    end else if (!hold) begin
      if (stop_det) begin
        std_d = 1'b0;
        spd_d = 1'b1;
      end else if (start_det) begin
        std_d = 1'b1;
        spd_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_q <= 1'b0;
      spd_q <= 1'b0;
    end else begin
      std_q <= std_d;
      spd_q <= spd_d;
    end
  end
endmodule

// File: rtl/i2c_mstat_reg.sv
module i2c_mstat_reg
  import i2c_mstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en,
  input  logic              wkup_en,
  input  logic              start_gen,
  input  logic              stop_det,
  input  logic              start_det,
  input  logic              arb_lost,
  input  logic              comm_rel,
  input  logic              ext_code,
  input  logic              addr_match,
  input  logic              dir_upd,
  input  logic              dir_tx,
  input  logic              ack_upd,
  input  logic              ack_val,
  input  logic              rd_stb,
  input  logic              rd_bit,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [STAT_W-1:0] stat
);
  bus_ev_t             ev;
  logic                hold_w;
  logic                ald_rd_clr_w;
  logic                mst_w, ald_w, std_w, spd_w;
  logic [N_STICKY-1:0] sticky_w;
  logic [N_LOAD-1:0]   load_w;

  assign ev = '{start_gen: start_gen, stop_det: stop_det, start_det: start_det,
                arb_lost: arb_lost, comm_rel: comm_rel};

  assign ald_rd_clr_w = rd_clears_ald(rd_stb, rd_bit, rd_sel);

  i2c_mstat_wake u_wake (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .wkup_en(wkup_en),
    .start_det(start_det), .stop_det(stop_det), .hold(hold_w)
  );

  i2c_mstat_arb u_arb (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .hold(hold_w), .ev(ev),
    .ald_rd_clr(ald_rd_clr_w), .mst(mst_w), .ald(ald_w)
  );

  i2c_mstat_evflags u_flags (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .hold(hold_w),
    .start_det(start_det), .stop_det(stop_det),
    .sticky_set({ext_code, addr_match}),
    .load_upd({dir_upd, ack_upd}),
    .load_val({dir_tx, ack_val}),
    .sticky_q(sticky_w), .load_q(load_w),
    .std_q(std_w), .spd_q(spd_w)
  );

  always_comb begin
    stat          = '0;
    stat[BIT_MST] = mst_w;
    stat[BIT_ALD] = ald_w;
    stat[BIT_EXC] = sticky_w[1];
    stat[BIT_ADM] = sticky_w[0];
    stat[BIT_DIR] = load_w[1];
    stat[BIT_ACK] = load_w[0];
    stat[BIT_STD] = std_w;
    stat[BIT_SPD] = spd_w;
  end
endmodule

// File: rtl/i2c_mstat_chk.sv
module i2c_mstat_chk
  import i2c_mstat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              if_en,
  input logic              start_gen,
  input logic              stop_det,
  input logic              start_det,
  input logic              arb_lost,
  input logic              comm_rel,
  input logic              hold,
  input logic              ald_rd_clr,
  input logic [STAT_W-1:0] stat
);
  // R7
  en_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> stat == '0);

  // R2
  mst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[BIT_MST]) |-> $past(start_gen));

  // R4
  arb_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && !hold && arb_lost) |=> (!stat[BIT_MST] && stat[BIT_ALD]));

  // R3
  mst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && !hold && (stop_det || comm_rel)) |=> !stat[BIT_MST]);

  // R5
  ald_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && !hold && ald_rd_clr && !arb_lost) |=> !stat[BIT_ALD]);

  // R8
  det_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[BIT_STD] && stat[BIT_SPD]));

  // R8
  start_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && start_det && !stop_det) |=> (stat[BIT_STD] && !stat[BIT_SPD]));

  // R11
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && hold) |=> $stable(stat));
endmodule

bind i2c_mstat_reg i2c_mstat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_en(if_en), .start_gen(start_gen),
  .stop_det(stop_det), .start_det(start_det), .arb_lost(arb_lost),
  .comm_rel(comm_rel), .hold(hold_w), .ald_rd_clr(ald_rd_clr_w), .stat(stat)
);

// File: tb/i2c_mstat_reg_test.sv
module i2c_mstat_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_en, wkup_en, start_gen, stop_det, start_det, arb_lost, comm_rel;
  logic ext_code, addr_match, dir_upd, dir_tx, ack_upd, ack_val;
  logic rd_stb, rd_bit;
  logic [2:0] rd_sel;
  logic [7:0] stat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_stat;
  logic m_wkq, m_frz;

  always #2 clk = ~clk;

  i2c_mstat_reg uut (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .wkup_en(wkup_en),
    .start_gen(start_gen), .stop_det(stop_det), .start_det(start_det),
    .arb_lost(arb_lost), .comm_rel(comm_rel), .ext_code(ext_code),
    .addr_match(addr_match), .dir_upd(dir_upd), .dir_tx(dir_tx),
    .ack_upd(ack_upd), .ack_val(ack_val), .rd_stb(rd_stb), .rd_bit(rd_bit),
    .rd_sel(rd_sel), .stat(stat)
  );

  // Reference next-state, written from the requirements
  function automatic logic [7:0] ref_next(input logic [7:0] s, input logic frz_q);
    logic [7:0] n;
    if (!if_en) return 8'h00;
    if (frz_q && !(start_det || stop_det)) return s;            // R11
    n = s;
    n[7] = (arb_lost || stop_det || comm_rel) ? 1'b0 : (start_gen ? 1'b1 : s[7]);
    if (arb_lost) n[6] = 1'b1;
    else if (rd_stb && (rd_bit == 1'b0 || rd_sel != 3'd6)) n[6] = 1'b0;
    n[5] = ext_code   ? 1'b1 : ((start_det || stop_det) ? 1'b0 : s[5]);
    n[4] = addr_match ? 1'b1 : ((start_det || stop_det) ? 1'b0 : s[4]);
    n[3] = dir_upd ? dir_tx  : (stop_det ? 1'b0 : s[3]);
    n[2] = ack_upd ? ack_val : (stop_det ? 1'b0 : s[2]);
    if (stop_det)       n[1:0] = 2'b01;
    else if (start_det) n[1:0] = 2'b10;
    return n;
  endfunction

  function automatic string tag_of(input logic [7:0] d, input logic en, input logic fz);
    if (!en)  return "R7";
    if (fz)   return "R11";
    if (d[7]) return "R3";
    if (d[6]) return "R5";
    if (d[5] || d[4]) return "R9";
    if (d[3] || d[2]) return "R10";
    return "R8";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: stat=%02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    start_gen = 0; stop_det = 0; start_det = 0; arb_lost = 0; comm_rel = 0;
    ext_code = 0; addr_match = 0; dir_upd = 0; dir_tx = 0; ack_upd = 0;
    ack_val = 0; rd_stb = 0; rd_bit = 0; rd_sel = 3'd0;
  endtask

  // Apply current inputs for one clock, then compare against the model
  task automatic step(input string req);
    logic [7:0] exp;
    logic fz;
    fz = m_frz && !(start_det || stop_det) && if_en;
    exp = ref_next(m_stat, m_frz);
    m_frz = if_en && !(start_det || stop_det) && (m_frz || (m_wkq && !wkup_en));
    m_wkq = if_en ? wkup_en : 1'b0;
    m_stat = exp;
    @(posedge clk);
    @(negedge clk);
    chk((req == "") ? tag_of(stat ^ exp, if_en, fz) : req, stat, exp);
    idle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: stat=%02h expected completion", stat);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    if_en = 1; wkup_en = 0;
    m_stat = 8'h00; m_wkq = 0; m_frz = 0;
    repeat (3) @(negedge clk);
    chk("R1", stat, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1", stat, 8'h00);

    start_gen = 1; step("R2"); chk("R2", stat, 8'h80);
    arb_lost = 1;  step("R4"); chk("R4", stat, 8'h40);
    rd_stb = 1; rd_bit = 0;
    chk("R5", stat, 8'h40);                         // pre-clear value during strobe
    step("R5"); chk("R5", stat, 8'h00);
    arb_lost = 1; rd_stb = 1; step("R5"); chk("R5", stat, 8'h40);
    start_gen = 1; arb_lost = 1; step("R3"); chk("R3", stat, 8'h40);
    rd_stb = 1; rd_bit = 1; rd_sel = 3'd6; step("R6"); chk("R6", stat, 8'h40);
    rd_stb = 1; rd_bit = 1; rd_sel = 3'd3; step("R6"); chk("R6", stat, 8'h00);
    start_gen = 1; step("R2");
    comm_rel = 1;  step("R3"); chk("R3", stat, 8'h00);
    start_gen = 1; step("R2");
    stop_det = 1;  step("R3"); chk("R3", stat, 8'h01);
    start_det = 1; step("R8"); chk("R8", stat, 8'h02);
    start_det = 1; stop_det = 1; step("R8"); chk("R8", stat, 8'h01);
    ext_code = 1; addr_match = 1; step("R9"); chk("R9", stat, 8'h31);
    start_det = 1; addr_match = 1; step("R9"); chk("R9", stat, 8'h12);
    dir_upd = 1; dir_tx = 1; ack_upd = 1; ack_val = 1; step("R10"); chk("R10", stat, 8'h1e);
    stop_det = 1; step("R10"); chk("R10", stat, 8'h01);
    // R11: wakeup hold
    start_gen = 1; wkup_en = 1; step("R11");
    wkup_en = 0; step("R11"); chk("R11", stat, 8'h81);
    arb_lost = 1; step("R11"); chk("R11", stat, 8'h81);
    rd_stb = 1; ext_code = 1; step("R11"); chk("R11", stat, 8'h81);
    stop_det = 1; step("R11"); chk("R11", stat, 8'h01);
    arb_lost = 1; step("R11"); chk("R11", stat, 8'h41);
    // R7: enable low
    start_gen = 1; step("R7");
    if_en = 0; step("R7"); chk("R7", stat, 8'h00);
    start_gen = 1; arb_lost = 1; start_det = 1; step("R7"); chk("R7", stat, 8'h00);
    if_en = 1; step("R7"); chk("R7", stat, 8'h00);

    for (int i = 0; i < 6000; i++) begin
      if_en      = ($urandom % 64) != 0;
      if (($urandom % 40) == 0) wkup_en = ~wkup_en;
      start_gen  = ($urandom % 8) == 0;
      stop_det   = ($urandom % 24) == 0;
      start_det  = ($urandom % 24) == 0;
      arb_lost   = ($urandom % 10) == 0;
      comm_rel   = ($urandom % 16) == 0;
      ext_code   = ($urandom % 12) == 0;
      addr_match = ($urandom % 12) == 0;
      dir_upd    = ($urandom % 8) == 0;
      dir_tx     = 1'($urandom);
      ack_upd    = ($urandom % 8) == 0;
      ack_val    = 1'($urandom);
      rd_stb     = ($urandom % 6) == 0;
      rd_bit     = 1'($urandom);
      rd_sel     = 3'($urandom);
      step("");
    end

    done = 1;
    summary();
  end
endmodule